// File: doc/BRIEF.md
# Per-Channel Feature Map Register Block

This block decides which of the 32 time slots of a framer each per-channel feature acts on. Every feature has its own 32-bit channel map, and the block drives all of these maps out to the feature logic. The host never addresses a feature map directly. Instead, it first loads a feature-select register with one bit per feature. It then writes map bytes through four byte-wide data windows.

A write to a data window goes into that byte of every feature whose select bit is set. One write can therefore program the same channel pattern into several features, such as the transmit and receive error-rate testers, which are select bits 0 and 4. Reading a data window is only meaningful when exactly one select bit is set. With zero or several bits set, the read returns zero.

The host bus is a simple synchronous port with an address, write data, a write strobe and read data. Read data is registered. It shows the state at the clock edge that samples the address, and it is valid one cycle after the address is presented.

Top module: `pcm_channel_map`

## Requirements
- R1: After reset, the select register, every feature map and the read data are all zero.
- R2: A write to address 0 loads the select register. A read of address 0 returns it, with bit f selecting feature f.
- R3: A write to address 1+k (k = 0..3) loads the write data into byte k, which is map bits 8k+7..8k, of every feature whose select bit is set.
- R4: A data write leaves unchanged the map of every feature whose select bit is clear, including the case where no select bit is set.
- R5: Channel n (1..32) is map bit n-1, held in byte (n-1)/8 at bit (n-1) mod 8, and it drives chan_en bit 32*f + n-1 for feature f. For example, channels 9 to 12 are byte value 0x0F at address 2, and channels 20 and 21 are 0x18 at address 3.
- R6: A read of address 1+k with exactly one select bit set returns byte k of that feature's map.
- R7: A read of address 1+k with zero or several select bits set returns 0x00.
- R8: host_rdata holds the value for the address sampled at the previous rising edge. A write in that same cycle is not yet visible.
- R9: Addresses 5 to 7 are unmapped. Writes to them change no state, and reads of them return 0x00.
- R10: A data write to byte k changes no other byte of any map.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register address: 0 selects, 1 to 4 are map bytes 0 to 3 |
| host_wdata | input | 8 | Write data |
| host_we | input | 1 | Write strobe, one write per cycle while high |
| host_rdata | output | 8 | Registered read data |
| chan_en | output | 256 | Channel maps, feature f in bits 32f+31..32f |

## Verification
A write is sampled at one rising edge. The select register and the maps on chan_en show the new value right after that edge, so the bench compares chan_en at the following falling edge. A read result is due exactly one edge after its address is driven. The driver pushes each expected byte into a queue stamped with its due cycle. The monitor pops the item and compares it only on the falling edge of that cycle, so a value that arrives early or late is reported. Expected values come from a bench-side model of the select register and the eight maps.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
    localparam int unsigned BYTE_W        = 8;
    localparam int unsigned SEL_ADDR      = 0;
    localparam int unsigned DATA_ADDR_LO  = 1;
endpackage

// File: rtl/pcm_addr_decode.sv
module pcm_addr_decode
    import pcm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 3,
    parameter int unsigned NUM_BYTES = 4
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 sel_hit,
    output logic [NUM_BYTES-1:0] byte_hit
);
    always_comb begin
        sel_hit = (addr == ADDR_W'(SEL_ADDR));
    end

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte_dec
        always_comb begin
            byte_hit[k] = (addr == ADDR_W'(DATA_ADDR_LO + k));
        end
    end
endmodule

// File: rtl/pcm_feature_map.sv
module pcm_feature_map
    import pcm_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned CHAN     = NUM_BYTES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 feat_sel,
    input  logic                 wr_en,
    input  logic [NUM_BYTES-1:0] byte_hit,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [CHAN-1:0]      map
);
    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (wr_en && feat_sel && byte_hit[k]) begin
                st_d.bytes[k] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign map = st_q.bytes;

    assert_unselected_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!feat_sel || !wr_en) |=> $stable(st_q));

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_chk
        assert_byte_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && feat_sel && byte_hit[k]) |=> (map[k*BYTE_W +: BYTE_W] == $past(wdata)));
        assert_byte_isolation_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && byte_hit[k]) |=> $stable(st_q.bytes[k]));
    end
endmodule

// File: rtl/pcm_read_mux.sv
module pcm_read_mux
    import pcm_pkg::*;
#(
    parameter int unsigned NUM_FEAT  = 8,
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned CHAN     = NUM_BYTES * BYTE_W
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_FEAT-1:0]                sel_q,
    input  logic                               sel_hit,
    input  logic [NUM_BYTES-1:0]               byte_hit,
    input  logic [NUM_FEAT-1:0][CHAN-1:0]      maps,
    output logic [BYTE_W-1:0]                  rdata
);
    typedef struct packed {
        logic [BYTE_W-1:0] rdata;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic [CHAN-1:0] picked;
    logic            single;

    always_comb begin
        picked = '0;
        for (int f = 0; f < NUM_FEAT; f++) begin
            if (sel_q[f]) picked = picked | maps[f];
        end
        single = ($countones(sel_q) == 1);
    end

    always_comb begin
        st_d.rdata = '0;
        if (sel_hit) begin
            st_d.rdata = BYTE_W'(sel_q);
        end else if (single) begin
            for (int k = 0; k < NUM_BYTES; k++) begin
                if (byte_hit[k]) st_d.rdata = picked[k*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;

    assert_ambiguous_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|byte_hit) && ($countones(sel_q) != 1)) |=> (rdata == '0));
    assert_sel_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_hit |=> (rdata == BYTE_W'($past(sel_q))));
    assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit[0] && sel_q[0] && $countones(sel_q) == 1)
            |=> (rdata == $past(maps[0][BYTE_W-1:0])));
endmodule

// File: rtl/pcm_channel_map.sv
module pcm_channel_map
    import pcm_pkg::*;
#(
    parameter int unsigned NUM_FEAT  = 8,
    parameter int unsigned NUM_BYTES = 4,
    parameter int unsigned ADDR_W    = 3,
    localparam int unsigned CHAN     = NUM_BYTES * BYTE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [BYTE_W-1:0]        host_wdata,
    input  logic                     host_we,
    output logic [BYTE_W-1:0]        host_rdata,
    output logic [NUM_FEAT*CHAN-1:0] chan_en
);
    typedef struct packed {
        logic [NUM_FEAT-1:0] sel;
    } top_state_t;

    top_state_t st_d, st_q;
    logic                          sel_hit;
    logic [NUM_BYTES-1:0]          byte_hit;
    logic [NUM_FEAT-1:0][CHAN-1:0] maps;

    pcm_addr_decode #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) i_dec (
        .addr     (host_addr),
        .sel_hit  (sel_hit),
        .byte_hit (byte_hit)
    );

    always_comb begin
        st_d = st_q;
        if (host_we && sel_hit) st_d.sel = host_wdata[NUM_FEAT-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar f = 0; f < NUM_FEAT; f++) begin : g_feat
        pcm_feature_map #(.NUM_BYTES(NUM_BYTES)) i_map (
            .clk      (clk),
            .rst_n    (rst_n),
            .feat_sel (st_q.sel[f]),
            .wr_en    (host_we),
            .byte_hit (byte_hit),
            .wdata    (host_wdata),
            .map      (maps[f])
        );
    end

    pcm_read_mux #(.NUM_FEAT(NUM_FEAT), .NUM_BYTES(NUM_BYTES)) i_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_q    (st_q.sel),
        .sel_hit  (sel_hit),
        .byte_hit (byte_hit),
        .maps     (maps),
        .rdata    (host_rdata)
    );

    assign chan_en = maps;

    assert_sel_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_W'(SEL_ADDR))
            |=> (st_q.sel == $past(host_wdata[NUM_FEAT-1:0])));
    assert_decode_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_hit, byte_hit}));
    assert_unmapped_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr > ADDR_W'(NUM_BYTES)) |=> ($stable(st_q) && $stable(chan_en) && host_rdata == '0));
endmodule

// File: tb/test_pcm_channel_map.sv
module test_pcm_channel_map;
    localparam int CLK_PERIOD = 10;
    localparam int NF = 8;

    logic         clk = 0;
    logic         rst_n = 0;
    logic [2:0]   host_addr = '0;
    logic [7:0]   host_wdata = '0;
    logic         host_we = 0;
    logic [7:0]   host_rdata;
    logic [NF*32-1:0] chan_en;

    pcm_channel_map i_pcm_channel_map (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_we(host_we), .host_rdata(host_rdata), .chan_en(chan_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [7:0] exp; string tag; int due; } item_t;
    item_t sb[$];
    int cyc = 0, checks = 0, errors = 0;
    bit done = 0;
    logic [7:0]  m_sel;
    logic [31:0] m_map [NF];

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compare each read result on its due cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (host_rdata !== it.exp) begin
                errors++;
                $display("FAIL %s read: got %02h exp %02h", it.tag, host_rdata, it.exp);
            end
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h exp %08h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] a, input logic [7:0] d, input logic w);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_we = w;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        drive(a, d, 1'b1);
        if (a == 0) m_sel = d;
        else if (a <= 4)
            for (int f = 0; f < NF; f++) if (m_sel[f]) m_map[f][8*(a-1) +: 8] = d;
    endtask

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        if (a == 0) return m_sel;
        if (a <= 4 && $countones(m_sel) == 1)
            for (int f = 0; f < NF; f++) if (m_sel[f]) return m_map[f][8*(a-1) +: 8];
        return 8'h00;
    endfunction

    task automatic rd(input logic [2:0] a, input string tag);
        item_t it;
        drive(a, 8'h00, 1'b0);
        it.exp = exp_rd(a); it.tag = tag; it.due = cyc + 1;
        sb.push_back(it);
    endtask

    task automatic check_maps(input string tag);
        drive(3'd0, 8'h00, 1'b0);
        for (int f = 0; f < NF; f++) chk(chan_en[32*f +: 32], m_map[f], tag);
    endtask

    task automatic do_reset();
        drive(3'd0, 8'h00, 1'b0);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_sel = '0;
        for (int f = 0; f < NF; f++) m_map[f] = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk(32'(host_rdata), 32'h0, "R1 rdata");
        check_maps("R1 maps");
        rd(3'd0, "R1 sel");

        // R2 select load; R3/R5 mapping of channels 9-12, 20, 21 to two features
        wr(3'd0, 8'h11);
        rd(3'd0, "R2");
        wr(3'd1, 8'h00); wr(3'd2, 8'h0F); wr(3'd3, 8'h18); wr(3'd4, 8'h00);
        check_maps("R3 R4");
        chk(chan_en[31:0],    32'h0018_0F00, "R5 feat0");
        chk(chan_en[159:128], 32'h0018_0F00, "R5 feat4");
        rd(3'd2, "R7 two set");

        // R6 single-feature readback
        wr(3'd0, 8'h01);
        rd(3'd2, "R6"); rd(3'd3, "R6"); rd(3'd1, "R6");

        // R4/R10 only selected feature, only addressed byte
        wr(3'd0, 8'h10);
        wr(3'd1, 8'hA5);
        check_maps("R4 R10");
        rd(3'd1, "R6 feat4"); rd(3'd3, "R10");

        // R4/R7 with no select bit
        wr(3'd0, 8'h00);
        wr(3'd4, 8'hFF);
        check_maps("R4 none");
        rd(3'd1, "R7 none");

        // R9 unmapped addresses
        wr(3'd0, 8'hFF);
        wr(3'd5, 8'h3C); wr(3'd7, 8'hC3);
        check_maps("R9 maps");
        rd(3'd0, "R9 sel"); rd(3'd5, "R9 rd5"); rd(3'd6, "R9 rd6");

        // R3 broadcast to all features
        wr(3'd3, 8'h5A);
        check_maps("R3 all");
        for (int f = 0; f < NF; f++) begin
            wr(3'd0, 8'(1 << f));
            rd(3'd3, "R3 each");
        end

        // R8 write and read same cycle: read shows old value
        wr(3'd0, 8'h02);
        begin
            item_t it;
            drive(3'd2, 8'h77, 1'b1);
            it.exp = exp_rd(3'd2); it.tag = "R8 old"; it.due = cyc + 1;
            sb.push_back(it);
            m_map[1][15:8] = 8'h77;
        end
        rd(3'd2, "R8 new");

        // R1 reset mid-run
        repeat (3) drive(3'd0, 8'h00, 1'b0);
        do_reset();
        chk(32'(host_rdata), 32'h0, "R1 rdata again");
        check_maps("R1 maps again");
        rd(3'd0, "R1 sel again");

        repeat (4) drive(3'd0, 8'h00, 1'b0);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R8: got %0d pending exp 0", sb.size());
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule